// File: doc/BRIEF.md
# Dynamic Tagless Loop Buffer Controller

This block is a tiny instruction buffer and its controller, placed beside the L1 instruction path of a small embedded core. It watches the fetch stream and the branch information decoded for each fetched word. When a taken short backward branch appears, it captures the following iteration of that loop into the buffer as L1 delivers each word. After one complete and uninterrupted iteration, it raises a select line that steers the fetch multiplexer to the buffer. Later iterations are then served without any L1 access.

The buffer has no address tags and never misses. An entry is addressed only by its distance from the loop's first instruction. The controller supplies a word only when the fetch address is exactly the one it expects next. Any change of control flow other than the loop-closing branch returns fetching to L1. Fetch addresses and branch offsets count instructions, not bytes.

The fetch side is a one-way stream qualified by `fetch_valid`. The block applies no back-pressure and has no ready signal: it follows whatever the core fetches. A cycle with `fetch_valid` low is ignored.

Top module: `dyn_loop_cache`

## Requirements
- R1: A cycle with `fetch_valid` low leaves the controller state unchanged and keeps `lc_sel` low. The next valid fetch resumes exactly where the stream left off.
- R2: A fetch qualifies as a short backward branch when all of these hold: `br_taken` is 1, `sbb_flag` is 1, and `br_offset` (two's complement, in instructions) is negative with a magnitude from 1 to DEPTH-1. The loop runs from the target (fetch_addr + br_offset) through the branch itself, so it is magnitude+1 entries long. A loop of DEPTH entries (offset -(DEPTH-1)) is accepted.
- R3: From idle, a qualifying branch starts a fill. `lc_sel` stays low during the fill, so L1 serves every fetch.
- R4: During a fill, each valid fetch whose address equals loop start plus the fill index is written into the entry at that index, and the index advances by one.
- R5: When the closing branch is taken at the last entry of a complete fill, the next fetch (the loop start) is served from the buffer. `lc_sel` is then 1 and `lc_instr` equals the word stored at that address. Service continues for every further iteration the closing branch takes.
- R6: A taken branch that is not the closing branch (for example a forward branch inside the loop) ends a fill or ends buffer service. The word at that branch is still delivered correctly, and the following fetch comes from L1.
- R7: When the closing branch falls through while the buffer is serving, that fetch is still served from the buffer and the next fetch returns to L1.
- R8: When the closing branch falls through during a fill, the controller goes idle without ever serving from the buffer.
- R9: A qualifying branch other than the closing branch, seen during a fill or during service, restarts the fill with the new loop's start and length.
- R10: `lc_sel` is 1 only when the fetch address equals the address the controller expects next. On a mismatch (a redirect with no branch), L1 serves that fetch and the controller goes idle. Every word served from the buffer equals the program memory word at the fetch address.
- R11: After reset the controller is idle. `lc_instr` reads 0 whenever `lc_sel` is 0.
- R12: A taken backward branch with `sbb_flag` clear, or with an offset magnitude of DEPTH or more, starts no fill, and `lc_sel` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Qualifies the fetch fields in this cycle |
| fetch_addr | input | ADDR_W | Instruction address being fetched (instruction units) |
| l1_instr | input | INSTR_W | Word returned by L1 for `fetch_addr` |
| br_taken | input | 1 | Fetched instruction is a branch that is taken |
| sbb_flag | input | 1 | Decoder marks the instruction as a loop-closing branch type |
| br_offset | input | OFF_W | Signed branch displacement in instructions |
| lc_instr | output | INSTR_W | Word from the buffer, 0 when not selected |
| lc_sel | output | 1 | Fetch mux select: 1 picks `lc_instr`, 0 picks L1 |

## Verification
The assertions check several properties on every cycle. Entry into a fill must follow a taken loop-closing branch, and entry into service must follow a taken branch during a fill. A forward branch or a fall-through at the last entry must drop service on the next cycle. Consecutive served fetches with no branch between them must have consecutive addresses, the state must hold across idle fetch cycles, and the index must never pass the loop's last entry. Only the bench's scenarios can show the rest: that the served words are the right ones, that fills restart on nested branches, that out-of-range offsets and unmarked branches are ignored, that a full DEPTH-entry loop is accepted, and that a redirect with no branch hands fetching back to L1.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [1:0] {
    LC_IDLE  = 2'd0,
    LC_FILL  = 2'd1,
    LC_SERVE = 2'd2
  } lc_state_e;
endpackage

// File: rtl/lc_sbb_detect.sv
// Qualifies a fetched branch as a loop-closing short backward branch and
// derives the loop start address and last buffer index from its offset.
module lc_sbb_detect #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int DEPTH  = 64,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              br_taken,
  input  logic              sbb_flag,
  input  logic [OFF_W-1:0]  br_offset,
  output logic              hit,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [IDX_W-1:0]  span
);
  localparam logic [OFF_W-1:0] MAX_MAG = OFF_W'(DEPTH - 1);

  logic [OFF_W-1:0]  mag;
  logic              negative;
  logic              in_range;
  logic [ADDR_W-1:0] off_ext;

  always_comb begin
    negative = br_offset[OFF_W-1];
    mag      = OFF_W'(0) - br_offset;
    in_range = negative && (mag <= MAX_MAG);
    hit      = fetch_valid && br_taken && sbb_flag && in_range;
    off_ext  = {{(ADDR_W-OFF_W){br_offset[OFF_W-1]}}, br_offset};
    tgt_addr = fetch_addr + off_ext;
    span     = mag[IDX_W-1:0];
  end
endmodule

// File: rtl/lc_store.sv
// Tagless loop buffer storage: one write port, one combinational read port.
module lc_store #(
  parameter int DEPTH   = 64,
  parameter int INSTR_W = 32,
  parameter int IDX_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [INSTR_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [INSTR_W-1:0] rd_data
);
  logic [INSTR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/lc_ctrl.sv
// Loop buffer controller: idle / fill / serve state machine.
module lc_ctrl
  import lc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 64,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              br_taken,
  input  logic              hit,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [IDX_W-1:0]  span,
  output lc_state_e         state,
  output logic [IDX_W-1:0]  idx,
  output logic [IDX_W-1:0]  last_idx,
  output logic              wr_en,
  output logic              sel
);
  lc_state_e         state_n;
  logic [IDX_W-1:0]  idx_n, last_n;
  logic [ADDR_W-1:0] start_addr, start_n;
  logic              addr_match, at_last, close_hit;

  always_comb begin
    addr_match = (fetch_addr == start_addr + ADDR_W'(idx));
    at_last    = (idx == last_idx);
    close_hit  = addr_match && at_last && br_taken;

    state_n = state;
    idx_n   = idx;
    last_n  = last_idx;
    start_n = start_addr;

    if (fetch_valid) begin
      if (state == LC_IDLE) begin
        if (hit) begin
          state_n = LC_FILL;
          idx_n   = '0;
          last_n  = span;
          start_n = tgt_addr;
        end
      end else if (close_hit) begin
        state_n = LC_SERVE;
        idx_n   = '0;
      end else if (hit) begin
        state_n = LC_FILL;
        idx_n   = '0;
        last_n  = span;
        start_n = tgt_addr;
      end else if (!addr_match || br_taken || at_last) begin
        state_n = LC_IDLE;
        idx_n   = '0;
      end else begin
        idx_n = idx + IDX_W'(1);
      end
    end

    wr_en = fetch_valid && (state == LC_FILL) && addr_match;
    sel   = fetch_valid && (state == LC_SERVE) && addr_match;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= LC_IDLE;
      idx        <= '0;
      last_idx   <= '0;
      start_addr <= '0;
    end else begin
      state      <= state_n;
      idx        <= idx_n;
      last_idx   <= last_n;
      start_addr <= start_n;
    end
  end
endmodule

// File: rtl/dyn_loop_cache.sv
module dyn_loop_cache
  import lc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32,
  parameter int OFF_W   = 12,
  parameter int DEPTH   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_valid,
  input  logic [ADDR_W-1:0]  fetch_addr,
  input  logic [INSTR_W-1:0] l1_instr,
  input  logic               br_taken,
  input  logic               sbb_flag,
  input  logic [OFF_W-1:0]   br_offset,
  output logic [INSTR_W-1:0] lc_instr,
  output logic               lc_sel
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              sbb_hit;
  logic [ADDR_W-1:0] sbb_tgt;
  logic [IDX_W-1:0]  sbb_span;
  lc_state_e         ctl_state;
  logic [IDX_W-1:0]  ctl_idx, ctl_last;
  logic              ctl_wr, ctl_sel;
  logic [INSTR_W-1:0] rd_word;

  lc_sbb_detect #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_det (
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .br_taken(br_taken),
    .sbb_flag(sbb_flag), .br_offset(br_offset),
    .hit(sbb_hit), .tgt_addr(sbb_tgt), .span(sbb_span)
  );

  lc_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .br_taken(br_taken), .hit(sbb_hit), .tgt_addr(sbb_tgt), .span(sbb_span),
    .state(ctl_state), .idx(ctl_idx), .last_idx(ctl_last),
    .wr_en(ctl_wr), .sel(ctl_sel)
  );

  lc_store #(.DEPTH(DEPTH), .INSTR_W(INSTR_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .wr_en(ctl_wr), .wr_idx(ctl_idx), .wr_data(l1_instr),
    .rd_idx(ctl_idx), .rd_data(rd_word)
  );

  assign lc_sel   = ctl_sel;
  assign lc_instr = ctl_sel ? rd_word : '0;
endmodule

// File: rtl/lc_checker.sv
module lc_checker
  import lc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              br_taken,
  input logic              sbb_flag,
  input logic              lc_sel,
  input lc_state_e         state,
  input logic [IDX_W-1:0]  idx,
  input logic [IDX_W-1:0]  last_idx
);
  assert_hold_on_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> state == $past(state));

  assert_fill_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == LC_FILL) |-> $past(fetch_valid && br_taken && sbb_flag));

  assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != LC_IDLE) |-> idx <= last_idx);

  assert_serve_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == LC_SERVE) |-> $past(state == LC_FILL && fetch_valid && br_taken));

  assert_fwd_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_sel && br_taken && !sbb_flag) |=> state == LC_IDLE);

  assert_fallthru_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_sel && !br_taken && idx == last_idx) |=> state == LC_IDLE);

  assert_seq_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_sel && $past(lc_sel) && !$past(br_taken)) |-> fetch_addr == $past(fetch_addr) + 1);
endmodule

bind dyn_loop_cache lc_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
  .br_taken(br_taken), .sbb_flag(sbb_flag), .lc_sel(lc_sel),
  .state(ctl_state), .idx(ctl_idx), .last_idx(ctl_last)
);

// File: tb/dyn_loop_cache_test.sv
module dyn_loop_cache_test;
  localparam int ADDR_W = 32, INSTR_W = 32, OFF_W = 12, DEPTH = 64;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               fetch_valid = 1'b0;
  logic [ADDR_W-1:0]  fetch_addr = '0;
  logic [INSTR_W-1:0] l1_instr;
  logic               br_taken = 1'b0;
  logic               sbb_flag = 1'b0;
  logic [OFF_W-1:0]   br_offset = '0;
  logic [INSTR_W-1:0] lc_instr;
  logic               lc_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [31:0] pmem(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  assign l1_instr = pmem(fetch_addr);

  dyn_loop_cache #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .OFF_W(OFF_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .l1_instr(l1_instr), .br_taken(br_taken), .sbb_flag(sbb_flag), .br_offset(br_offset),
    .lc_instr(lc_instr), .lc_sel(lc_sel)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One fetch; outputs checked 1 ns after the falling-edge drive.
  task automatic step(input int a, input bit tk, input bit sb, input int off,
                      input bit exp_sel, input string tag);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a; br_taken = tk; sbb_flag = sb; br_offset = off[OFF_W-1:0];
    #1;
    chk(lc_sel == exp_sel, {tag, " select"}, 32'(lc_sel), 32'(exp_sel));
    if (lc_sel)
      chk(lc_instr == pmem(fetch_addr), {tag, " R10 buffer word"}, lc_instr, pmem(fetch_addr));
    else
      chk(lc_instr == '0, {tag, " R11 idle word"}, lc_instr, 32'h0);
  endtask

  task automatic gap(input string tag);
    @(negedge clk);
    fetch_valid = 1'b0; br_taken = 1'b0; sbb_flag = 1'b0; fetch_addr = 32'hFFFF;
    #1;
    chk(lc_sel == 1'b0, {tag, " gap select"}, 32'(lc_sel), 32'h0);
  endtask

  typedef struct packed {
    logic [15:0]       addr;
    logic              tk;
    logic              sb;
    logic signed [11:0] off;
    logic              sel;
  } vec_t;

  localparam int NV = 62;
  localparam vec_t VT [NV] = '{
    // R3 R4 R5 R7: loop 100..103
    '{16'd100,1'b0,1'b0,12'sd0,1'b0}, '{16'd101,1'b0,1'b0,12'sd0,1'b0},
    '{16'd102,1'b0,1'b0,12'sd0,1'b0}, '{16'd103,1'b1,1'b1,-12'sd3,1'b0},
    '{16'd100,1'b0,1'b0,12'sd0,1'b0}, '{16'd101,1'b0,1'b0,12'sd0,1'b0},
    '{16'd102,1'b0,1'b0,12'sd0,1'b0}, '{16'd103,1'b1,1'b1,-12'sd3,1'b0},
    '{16'd100,1'b0,1'b0,12'sd0,1'b1}, '{16'd101,1'b0,1'b0,12'sd0,1'b1},
    '{16'd102,1'b0,1'b0,12'sd0,1'b1}, '{16'd103,1'b1,1'b1,-12'sd3,1'b1},
    '{16'd100,1'b0,1'b0,12'sd0,1'b1}, '{16'd101,1'b0,1'b0,12'sd0,1'b1},
    '{16'd102,1'b0,1'b0,12'sd0,1'b1}, '{16'd103,1'b0,1'b1,-12'sd3,1'b1},
    '{16'd104,1'b0,1'b0,12'sd0,1'b0}, '{16'd105,1'b0,1'b0,12'sd0,1'b0},
    '{16'd106,1'b0,1'b0,12'sd0,1'b0},
    // R6 forward branch while serving, then R8 fall-through during fill
    '{16'd204,1'b1,1'b1,-12'sd4,1'b0},
    '{16'd200,1'b0,1'b0,12'sd0,1'b0}, '{16'd201,1'b0,1'b0,12'sd0,1'b0},
    '{16'd202,1'b0,1'b0,12'sd0,1'b0}, '{16'd203,1'b0,1'b0,12'sd0,1'b0},
    '{16'd204,1'b1,1'b1,-12'sd4,1'b0},
    '{16'd200,1'b0,1'b0,12'sd0,1'b1}, '{16'd201,1'b1,1'b0,12'sd2,1'b1},
    '{16'd203,1'b0,1'b0,12'sd0,1'b0}, '{16'd204,1'b1,1'b1,-12'sd4,1'b0},
    '{16'd200,1'b0,1'b0,12'sd0,1'b0}, '{16'd201,1'b0,1'b0,12'sd0,1'b0},
    '{16'd202,1'b0,1'b0,12'sd0,1'b0}, '{16'd203,1'b0,1'b0,12'sd0,1'b0},
    '{16'd204,1'b0,1'b1,-12'sd4,1'b0}, '{16'd205,1'b0,1'b0,12'sd0,1'b0},
    // R6 forward branch during fill
    '{16'd302,1'b1,1'b1,-12'sd2,1'b0}, '{16'd300,1'b0,1'b0,12'sd0,1'b0},
    '{16'd301,1'b1,1'b0,12'sd1,1'b0}, '{16'd302,1'b1,1'b1,-12'sd2,1'b0},
    '{16'd300,1'b0,1'b0,12'sd0,1'b0}, '{16'd301,1'b0,1'b0,12'sd0,1'b0},
    '{16'd302,1'b1,1'b1,-12'sd2,1'b0}, '{16'd300,1'b0,1'b0,12'sd0,1'b1},
    '{16'd301,1'b0,1'b0,12'sd0,1'b1}, '{16'd302,1'b0,1'b1,-12'sd2,1'b1},
    '{16'd303,1'b0,1'b0,12'sd0,1'b0},
    // R9 inner loop restarts the fill
    '{16'd503,1'b1,1'b1,-12'sd3,1'b0}, '{16'd500,1'b0,1'b0,12'sd0,1'b0},
    '{16'd501,1'b1,1'b1,-12'sd1,1'b0}, '{16'd500,1'b0,1'b0,12'sd0,1'b0},
    '{16'd501,1'b1,1'b1,-12'sd1,1'b0}, '{16'd500,1'b0,1'b0,12'sd0,1'b1},
    '{16'd501,1'b1,1'b1,-12'sd1,1'b1}, '{16'd500,1'b0,1'b0,12'sd0,1'b1},
    '{16'd501,1'b0,1'b1,-12'sd1,1'b1}, '{16'd502,1'b0,1'b0,12'sd0,1'b0},
    // R12 backward branch without the loop-branch mark
    '{16'd601,1'b1,1'b0,-12'sd1,1'b0}, '{16'd600,1'b0,1'b0,12'sd0,1'b0},
    '{16'd601,1'b1,1'b0,-12'sd1,1'b0}, '{16'd600,1'b0,1'b0,12'sd0,1'b0},
    '{16'd601,1'b0,1'b0,12'sd0,1'b0},  '{16'd602,1'b0,1'b0,12'sd0,1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: reset state, even with a qualifying branch presented
    fetch_valid = 1'b1; fetch_addr = 32'd10; br_taken = 1'b1; sbb_flag = 1'b1; br_offset = 12'hFFF;
    repeat (3) @(posedge clk);
    #1;
    chk(lc_sel == 1'b0, "R11 reset select", 32'(lc_sel), 32'h0);
    chk(lc_instr == '0, "R11 reset word", lc_instr, 32'h0);
    @(negedge clk);
    fetch_valid = 1'b0; br_taken = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++)
      step(int'(VT[i].addr), VT[i].tk, VT[i].sb, int'(VT[i].off), VT[i].sel,
           $sformatf("table row %0d", i));

    // R1: idle fetch cycles during fill and service
    step(800, 1'b0, 1'b0, 0, 1'b0, "R1");
    step(801, 1'b1, 1'b1, -1, 1'b0, "R1");
    step(800, 1'b0, 1'b0, 0, 1'b0, "R1");
    gap("R1");
    step(801, 1'b1, 1'b1, -1, 1'b0, "R1");
    gap("R1");
    step(800, 1'b0, 1'b0, 0, 1'b1, "R1");
    gap("R1");
    gap("R1");
    step(801, 1'b0, 1'b1, -1, 1'b1, "R1");
    step(802, 1'b0, 1'b0, 0, 1'b0, "R1");

    // R10: redirect with no branch while serving
    step(902, 1'b1, 1'b1, -2, 1'b0, "R10");
    step(900, 1'b0, 1'b0, 0, 1'b0, "R10");
    step(901, 1'b0, 1'b0, 0, 1'b0, "R10");
    step(902, 1'b1, 1'b1, -2, 1'b0, "R10");
    step(900, 1'b0, 1'b0, 0, 1'b1, "R10");
    step(950, 1'b0, 1'b0, 0, 1'b0, "R10 redirect");
    step(901, 1'b0, 1'b0, 0, 1'b0, "R10 after redirect");

    // R2: full-depth loop (offset -63, 64 entries)
    step(2063, 1'b1, 1'b1, -63, 1'b0, "R2");
    for (int it = 0; it < 3; it++)
      for (int a = 2000; a <= 2063; a++)
        step(a, a == 2063 && it < 2, a == 2063, (a == 2063) ? -63 : 0,
             it > 0, "R2 depth loop");
    step(2064, 1'b0, 1'b0, 0, 1'b0, "R2");

    // R12: offset magnitude equal to DEPTH is not cached
    step(3064, 1'b1, 1'b1, -64, 1'b0, "R12");
    for (int it = 0; it < 2; it++)
      for (int a = 3000; a <= 3064; a++)
        step(a, a == 3064, a == 3064, (a == 3064) ? -64 : 0, 1'b0, "R12 too long");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule